// File: doc/BRIEF.md
# Serial Peripheral Port with Low-Power Gating

This block is a synchronous serial port that can run as the clock-driving master or as a slave driven by an external clock. Frames are 8 or 16 bits long and travel most significant bit first. Data is sampled on the rising edge of the serial clock and shifted on the falling edge. Software reaches the block through three registers with single-cycle reads and writes: control, status and data.

The block also takes three low-power requests: wait, retained stop and non-retained stop. While the bus side is gated, it is frozen. A slave keeps shifting on the external clock during that time. A frame that completes while gated is held in the shift register. Its receive-full flag, its interrupt and its copy into the data register are raised once, just after wake-up. A master frame that is caught by retained stop pauses in place and resumes cleanly. Non-retained stop clears every register.

Top module: `spi_lp_core`

## Requirements
- R1: After reset, control (address 0) reads 0, status (address 1) reads 0x0002 (bit 0 receive-full low, bit 1 transmit-empty high), data (address 2) reads 0 and `irq` is low.
- R2: In master mode (control bit 0 enable, bit 1 master), writing data starts an 8-bit frame. `sdo` sends the written byte MSB first on `sck_out` while `sel_n_out` is low. The byte sampled from `sdi` is placed in data bits 7:0 and receive-full is set.
- R3: With control bit 2 set, frames are 16 bits in both directions.
- R4: Receive-full clears only when a status read that saw it set is followed by a data read. A data read without that earlier status read leaves it set.
- R5: `irq` is high exactly when receive-full is set and control bit 3 (receive interrupt enable) is set.
- R6: With control bit 4 (wait halt) set and `wait_req` high, a slave frame that completes raises neither the flag nor the interrupt. On the second clock edge after `wait_req` falls, receive-full sets and the data register takes the received frame.
- R7: With control bit 4 clear, `wait_req` has no effect, and a frame completed during wait sets the flag at once.
- R8: Entering and leaving wait while no frame is in progress raises no flag and changes no data.
- R9: Retained stop (`stop_req`) acts whatever the value of control bit 4. A master frame in progress holds `sck_out` at a constant level and keeps `sel_n_out` low. After exit, the frame completes with correct data in both directions.
- R10: A slave keeps shifting during retained stop, driving the previously written data on `sdo`. The received frame is delivered after exit.
- R11: `off_req` returns all registers and `irq` to their reset values. They stay there after it is released.
- R12: After reset with no data write, a slave frame shifts out the shift register's contents, which are the last byte received before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus and oversampling clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe |
| bus_addr | input | 2 | register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 16 | write data |
| bus_rdata | output | 16 | read data, combinational from address |
| irq | output | 1 | receive interrupt |
| wait_req | input | 1 | wait mode request |
| stop_req | input | 1 | retained stop request |
| off_req | input | 1 | non-retained stop request |
| sck_out | output | 1 | master serial clock |
| sel_n_out | output | 1 | master select, low during a frame |
| sck_in | input | 1 | slave serial clock |
| sel_n_in | input | 1 | slave select, active low |
| sdi | input | 1 | serial data in |
| sdo | output | 1 | serial data out |

## Verification
The assertions assume that the low-power requests and the slave pins change slowly compared with `clk`. Slave inputs are oversampled through two flops, so each serial clock phase must last several bus cycles. The bench holds every slave clock phase for six cycles and changes `sdi` only while the slave clock is low. It raises and drops the power requests only on falling edges of `clk`, and it issues register accesses only while the bus side is awake, so that any read side effect takes place.

// File: rtl/spi_lp_core.sv
module spi_lp_core #(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  input  logic        wait_req,
  input  logic        stop_req,
  input  logic        off_req,
  output logic        sck_out,
  output logic        sel_n_out,
  input  logic        sck_in,
  input  logic        sel_n_in,
  input  logic        sdi,
  output logic        sdo
);
  localparam int DVW = $clog2(HALF_DIV) + 1;
  localparam logic [DVW-1:0] DIV_END = DVW'(HALF_DIV - 1);

  logic wait_s, stop_s, off_s;
  logic c_en, c_mst, c_wide, c_rxie, c_halt;
  logic [15:0] tx_buf, data_r, shreg;
  logic tx_full, rx_full, armed, pend;
  logic busy, sck_r, rxbit;
  logic [DVW-1:0] div;
  logic [3:0] bitcnt;
  logic [2:0] sck_q, ssn_q;
  logic [1:0] sdi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {wait_s, stop_s, off_s} <= 3'b000;
    else        {wait_s, stop_s, off_s} <= {wait_req, stop_req, off_req};

  wire frozen = stop_s | (wait_s & c_halt);
  wire bus_ok = ~frozen & ~off_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= 3'b000; ssn_q <= 3'b111; sdi_q <= 2'b00;
    end else begin
      sck_q <= {sck_q[1:0], sck_in};
      ssn_q <= {ssn_q[1:0], sel_n_in};
      sdi_q <= {sdi_q[0], sdi};
    end

  wire s_act  = ~ssn_q[1];
  wire slv_on = c_en & ~c_mst & ~off_s;
  wire mst_on = c_en & c_mst & ~off_s;

  wire m_start = mst_on & ~busy & tx_full & ~frozen;
  wire m_tick  = busy & ~frozen & (div == DIV_END);
  wire s_load  = slv_on & ~ssn_q[1] & ssn_q[2] & tx_full;
  wire s_rise  = slv_on & s_act & sck_q[1] & ~sck_q[2];
  wire s_fall  = slv_on & s_act & ~sck_q[1] & sck_q[2];

  wire load  = m_start | s_load;
  wire samp  = (m_tick & ~sck_r) | s_rise;
  wire shift = (m_tick & sck_r) | s_fall;
  wire last  = bitcnt == (c_wide ? 4'd15 : 4'd7);
  wire done  = shift & last;

  wire [15:0] sh_next = {shreg[14:0], rxbit};
  wire [15:0] cap_src = done ? sh_next : shreg;
  wire [15:0] cap_val = c_wide ? cap_src : {8'h00, cap_src[7:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; sck_r <= 1'b0; div <= '0; bitcnt <= '0; rxbit <= 1'b0;
    end else if (off_s) begin
      busy <= 1'b0; sck_r <= 1'b0; div <= '0; bitcnt <= '0; rxbit <= 1'b0;
    end else begin
      if (m_start) begin
        busy <= 1'b1; sck_r <= 1'b0; div <= '0; bitcnt <= '0;
      end else if (busy && !frozen) begin
        if (m_tick) begin
          div <= '0; sck_r <= ~sck_r;
        end else div <= div + 1'b1;
      end
      if (samp) rxbit <= c_mst ? sdi : sdi_q[1];
      if (shift) begin
        bitcnt <= last ? 4'd0 : bitcnt + 4'd1;
        if (last && c_mst) busy <= 1'b0;
      end
      if (!c_mst && ssn_q[1]) bitcnt <= '0;
    end

  always_ff @(posedge clk)
    if (load)       shreg <= tx_buf;
    else if (shift) shreg <= sh_next;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {c_en, c_mst, c_wide, c_rxie, c_halt} <= '0;
      tx_buf <= '0; data_r <= '0;
      tx_full <= 1'b0; rx_full <= 1'b0; armed <= 1'b0; pend <= 1'b0;
    end else if (off_s) begin
      {c_en, c_mst, c_wide, c_rxie, c_halt} <= '0;
      tx_buf <= '0; data_r <= '0;
      tx_full <= 1'b0; rx_full <= 1'b0; armed <= 1'b0; pend <= 1'b0;
    end else begin
      if (load) tx_full <= 1'b0;
      if (bus_ok && bus_wr) begin
        case (bus_addr)
          2'd0: {c_halt, c_rxie, c_wide, c_mst, c_en} <= bus_wdata[4:0];
          2'd2: begin tx_buf <= bus_wdata; tx_full <= 1'b1; end
          default: ;
        endcase
      end
      if (bus_ok && bus_rd) begin
        if (bus_addr == 2'd1 && rx_full) armed <= 1'b1;
        if (bus_addr == 2'd2 && armed) begin
          rx_full <= 1'b0; armed <= 1'b0;
        end
      end
      if (done && frozen) pend <= 1'b1;
      if ((done && !frozen) || (pend && !frozen)) begin
        rx_full <= 1'b1; data_r <= cap_val;
      end
      if (pend && !frozen) pend <= 1'b0;
    end

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = {11'd0, c_halt, c_rxie, c_wide, c_mst, c_en};
      2'd1:    bus_rdata = {14'd0, ~tx_full, rx_full};
      2'd2:    bus_rdata = data_r;
      default: bus_rdata = '0;
    endcase

  assign irq       = rx_full & c_rxie;
  assign sck_out   = sck_r;
  assign sel_n_out = ~busy;
  assign sdo       = c_wide ? shreg[15] : shreg[7];
endmodule

// File: rtl/spi_lp_core_chk.sv
module spi_lp_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frozen,
  input logic       off_s,
  input logic       stop_s,
  input logic       busy,
  input logic       sck_out,
  input logic       rx_full,
  input logic       pend,
  input logic       irq,
  input logic       bus_rd,
  input logic [1:0] bus_addr
);
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !rx_full) |=> !rx_full);

  // R6
  pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !frozen && !off_s) |=> rx_full);

  // R9
  sck_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_s && busy && !off_s) |=> $stable(sck_out));

  // R11
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_s |=> (!rx_full && !irq && !busy && !pend));

  // R4
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(off_s || (bus_rd && bus_addr == 2'd2)));
endmodule

bind spi_lp_core spi_lp_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frozen(frozen), .off_s(off_s), .stop_s(stop_s),
  .busy(busy), .sck_out(sck_out), .rx_full(rx_full), .pend(pend), .irq(irq),
  .bus_rd(bus_rd), .bus_addr(bus_addr)
);

// File: tb/spi_lp_core_test.sv
module spi_lp_core_test;
  localparam int CLK_NS = 10;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq, sck_out, sel_n_out, sdo;
  logic wait_req = 1'b0, stop_req = 1'b0, off_req = 1'b0;
  logic sck_in = 1'b0, sel_n_in = 1'b1, sdi = 1'b0;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  spi_lp_core uut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wait_req = 0; stop_req = 0; off_req = 0;
    sck_in = 0; sel_n_in = 1; sdi = 0; bus_wr = 0; bus_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic slave_frame(input logic [15:0] mo, input int n, output logic [15:0] seen);
    seen = '0;
    sel_n_in = 0; repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = mo[n-1-i]; repeat (H) @(negedge clk);
      seen = {seen[14:0], sdo};
      sck_in = 1; repeat (H) @(negedge clk);
      sck_in = 0; repeat (H) @(negedge clk);
    end
    sel_n_in = 1; repeat (H) @(negedge clk);
  endtask

  task automatic master_frame(input logic [15:0] resp, input int n, input int stop_at,
                              output logic [15:0] seen);
    logic held;
    seen = '0;
    wait (sel_n_out == 1'b0);
    for (int i = 0; i < n; i++) begin
      sdi = resp[n-1-i];
      @(posedge sck_out); #1 seen = {seen[14:0], sdo};
      @(negedge sck_out);
      if (i == stop_at) begin
        @(negedge clk); stop_req = 1;
        repeat (2) @(negedge clk); held = sck_out;
        for (int k = 0; k < 40; k++) begin
          @(negedge clk);
          if (sck_out !== held || sel_n_out !== 1'b0) begin
            check("R9 freeze", {14'd0, sel_n_out, sck_out}, {14'd0, 1'b0, held});
            break;
          end
        end
        check("R9 frozen low select", {15'd0, sel_n_out}, 16'd0);
        stop_req = 0;
      end
    end
    wait (sel_n_out == 1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); check("R1 status", v, 16'h0002);
    rd(2'd2, v); check("R1 data", v, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_master8();
    logic [15:0] v, s;
    do_reset();
    wr(2'd0, 16'h000B); wr(2'd2, 16'h003C);
    master_frame(16'h00A6, 8, -1, s);
    check("R2 sdo", s, 16'h003C);
    check("R5 irq set", {15'd0, irq}, 16'd1);
    rd(2'd1, v); check("R2 flag", v, 16'h0003);
    rd(2'd2, v); check("R2 data", v, 16'h00A6);
    rd(2'd1, v); check("R4 cleared", v, 16'h0002);
    check("R5 irq clear", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_master16();
    logic [15:0] v, s;
    do_reset();
    wr(2'd0, 16'h0007); wr(2'd2, 16'hBEEF);
    master_frame(16'h1234, 16, -1, s);
    check("R3 sdo", s, 16'hBEEF);
    rd(2'd2, v); check("R3 data", v, 16'h1234);
  endtask

  task automatic t_flag_clear();
    logic [15:0] v, s;
    do_reset();
    wr(2'd0, 16'h0003); wr(2'd2, 16'h0011);
    master_frame(16'h0055, 8, -1, s);
    check("R5 masked irq", {15'd0, irq}, 16'd0);
    rd(2'd2, v); rd(2'd1, v);
    check("R4 data-only read keeps flag", v, 16'h0003);
    rd(2'd2, v); rd(2'd1, v);
    check("R4 status then data clears", v, 16'h0002);
  endtask

  task automatic t_wait_halt();
    logic [15:0] v, s;
    do_reset();
    wr(2'd0, 16'h0019);
    fork
      slave_frame(16'h00C5, 8, s);
      begin repeat (3*H*3) @(negedge clk); wait_req = 1; end
    join
    repeat (20) @(negedge clk);
    check("R6 no irq in wait", {15'd0, irq}, 16'd0);
    peek(2'd1, v); check("R6 no flag in wait", v & 16'h0001, 16'h0000);
    peek(2'd2, v); check("R6 no copy in wait", v, 16'h0000);
    wait_req = 0;
    @(negedge clk); check("R6 not yet", {15'd0, irq}, 16'd0);
    @(negedge clk); check("R6 on wake", {15'd0, irq}, 16'd1);
    rd(2'd2, v); check("R6 data", v, 16'h00C5);
  endtask

  task automatic t_wait_nohalt();
    logic [15:0] v, s;
    do_reset();
    wr(2'd0, 16'h0009);
    wait_req = 1;
    slave_frame(16'h005E, 8, s);
    check("R7 irq in wait", {15'd0, irq}, 16'd1);
    rd(2'd2, v); check("R7 data", v, 16'h005E);
    wait_req = 0;
  endtask

  task automatic t_wait_idle();
    logic [15:0] v;
    do_reset();
    wr(2'd0, 16'h0019);
    wait_req = 1; repeat (50) @(negedge clk);
    wait_req = 0; repeat (10) @(negedge clk);
    rd(2'd1, v); check("R8 no flag", v, 16'h0002);
    rd(2'd2, v); check("R8 no data", v, 16'h0000);
  endtask

  task automatic t_stop_master();
    logic [15:0] v, s;
    do_reset();
    wr(2'd0, 16'h000B); wr(2'd2, 16'h005A);
    master_frame(16'h00C3, 8, 3, s);
    check("R9 sdo", s, 16'h005A);
    rd(2'd2, v); check("R9 data", v, 16'h00C3);
  endtask

  task automatic t_stop_slave();
    logic [15:0] v, s;
    do_reset();
    wr(2'd0, 16'h0019); wr(2'd2, 16'h0071);
    stop_req = 1;
    slave_frame(16'h0096, 8, s);
    check("R10 sdo during stop", s, 16'h0071);
    check("R10 no irq in stop", {15'd0, irq}, 16'd0);
    stop_req = 0; repeat (3) @(negedge clk);
    check("R10 irq after stop", {15'd0, irq}, 16'd1);
    rd(2'd2, v); check("R10 data", v, 16'h0096);
  endtask

  task automatic t_off();
    logic [15:0] v, s;
    do_reset();
    wr(2'd0, 16'h0009);
    slave_frame(16'h0033, 8, s);
    wr(2'd2, 16'h0044);
    off_req = 1; repeat (10) @(negedge clk);
    off_req = 0; repeat (3) @(negedge clk);
    rd(2'd0, v); check("R11 ctrl", v, 16'h0000);
    rd(2'd1, v); check("R11 status", v, 16'h0002);
    rd(2'd2, v); check("R11 data", v, 16'h0000);
    check("R11 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_leftover();
    logic [15:0] v, s;
    do_reset();
    wr(2'd0, 16'h0001);
    slave_frame(16'h00A5, 8, s);
    do_reset();
    wr(2'd0, 16'h0001);
    rd(2'd2, v); check("R12 data zero", v, 16'h0000);
    slave_frame(16'h0000, 8, s);
    check("R12 leftover out", s, 16'h00A5);
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_master8();
    t_master16();
    t_flag_clear();
    t_wait_halt();
    t_wait_nohalt();
    t_wait_idle();
    t_stop_master();
    t_stop_slave();
    t_off();
    t_leftover();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule